// File: doc/BRIEF.md
# Monochrome LCD Bus Frame Capture

This block sits quietly on the wires between a display controller and a monochrome row/column-driven LCD panel. It never drives the bus. It takes in four parallel pixel lines, a shift clock, a row latch strobe and a frame marker, and passes each through a two-flop synchroniser into the system clock. It finds the edges of those signals and rebuilds the whole picture in an on-chip frame buffer. Downstream logic can then read any single pixel by row and column.

Each falling edge of the shift clock carries four pixels. The highest data line holds the leftmost of the four. A rising latch strobe opens a new row. When the frame marker is high at that strobe, the row count returns to zero, so the capture locks onto the panel's frame sequence. A one-cycle `frame_done` pulse marks every completed picture. A sticky `overflow` flag records any row or column traffic that does not fit the geometry. The system clock must run at least four times faster than the shift clock.

Top module: `lcd_frame_capture`

## Requirements
- R1: The buffer holds ROWS x COLS one-bit pixels (default 64 x 128). When `rd_row`/`rd_col` are presented at one clock edge, `rd_pix` returns the stored pixel after that edge (one-cycle latency).
- R2: The data lines are sampled on each high-to-low transition of the synchronised shift clock. Within a transfer, `bus_data[3]` is pixel column 4n, `bus_data[2]` is 4n+1, `bus_data[1]` is 4n+2 and `bus_data[0]` is 4n+3, where n is the transfer index (0 to 31) within the row.
- R3: A rising edge on `bus_lp` while the shift clock is low clears the column position and moves the capture to the next row.
- R4: A rising edge on `bus_lp` (with the shift clock low) while `bus_frm` is high sets the row to 0, including part way through a frame, and raises `synced`.
- R5: After reset, until the first row start with `bus_frm` high, no bus traffic changes the frame buffer. During that time `synced`, `overflow` and `frame_done` stay low.
- R6: Shift-clock transfers after the 32nd in a row are not stored and set `overflow`. `overflow` then stays high until reset.
- R7: A row start after row 63 without `bus_frm` high sets `overflow`. Its data is not stored, and no frame-done pulse follows it.
- R8: `frame_done` is high for exactly one clock, right after the 32nd transfer of row 63 has been written.
- R9: During and after reset, `synced`, `overflow` and `frame_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_data | input | DW (4) | Parallel pixel lines from the LCD bus |
| bus_sclk | input | 1 | Pixel shift clock; data taken on its falling edge |
| bus_lp | input | 1 | Row latch strobe; rising edge starts a row |
| bus_frm | input | 1 | Frame marker, high through the first row |
| rd_row | input | $clog2(ROWS) | Read row address |
| rd_col | input | $clog2(COLS) | Read pixel column address |
| rd_pix | output | 1 | Pixel at the read address, one clock later |
| frame_done | output | 1 | One-clock pulse when a full frame has been captured |
| synced | output | 1 | High once a frame start has been seen since reset |
| overflow | output | 1 | Sticky flag for surplus transfers or rows |

## Verification
The bench builds the block with its default geometry: 128 columns, 64 rows and a 4-bit bus. At that size the 32-transfer row limit, the row 63 to row 64 boundary, and the frame-done pulse at the true end of a full-size frame are all reached. The bus runs with a shift-clock period of eight system clocks, which is close to the minimum 4x ratio. Separate frames with distinct pixel patterns separate real writes from stale contents. This exposes dropped, shifted or misordered nibbles, rows stored at the wrong index, and traffic that should have been ignored.

// File: rtl/lcd_frame_capture.sv
module lcd_frame_capture #(
  parameter int COLS = 128,
  parameter int ROWS = 64,
  parameter int DW   = 4,
  localparam int NIB = COLS / DW,
  localparam int CW  = $clog2(NIB + 1),
  localparam int RW  = $clog2(ROWS + 1),
  localparam int XW  = $clog2(COLS),
  localparam int YW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] bus_data,
  input  logic          bus_sclk,
  input  logic          bus_lp,
  input  logic          bus_frm,
  input  logic [YW-1:0] rd_row,
  input  logic [XW-1:0] rd_col,
  output logic          rd_pix,
  output logic          frame_done,
  output logic          synced,
  output logic          overflow
);

  localparam logic [RW-1:0] ROW_END  = RW'(ROWS);
  localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
  localparam logic [CW-1:0] COL_END  = CW'(NIB);
  localparam logic [CW-1:0] COL_LAST = CW'(NIB - 1);

  logic [DW+2:0] s1, s2;
  logic          sclk_q, lp_q;
  logic [RW-1:0] row;
  logic [CW-1:0] col;
  logic [COLS-1:0] mem [ROWS];

  wire [DW-1:0] s_data = s2[DW-1:0];
  wire s_sclk = s2[DW];
  wire s_lp   = s2[DW+1];
  wire s_frm  = s2[DW+2];

  wire sclk_fall = sclk_q & ~s_sclk;
  wire lp_rise   = ~lp_q & s_lp & ~s_sclk;
  wire row_ok    = row < ROW_END;
  wire wr        = sclk_fall & synced & row_ok & (col < COL_END);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
      sclk_q <= 1'b0;
      lp_q <= 1'b0;
    end else begin
      s1 <= {bus_frm, bus_lp, bus_sclk, bus_data};
      s2 <= s1;
      sclk_q <= s_sclk;
      lp_q <= s_lp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row <= ROW_END;
      col <= COL_END;
      synced <= 1'b0;
      overflow <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= wr && row == ROW_LAST && col == COL_LAST;
      if (lp_rise) begin
        col <= '0;
        if (s_frm) begin
          row <= '0;
          synced <= 1'b1;
        end else if (synced) begin
          if (row_ok) row <= row + 1'b1;
          if (row >= ROW_LAST) overflow <= 1'b1;
        end
      end else if (sclk_fall && synced && row_ok) begin
        if (col < COL_END) col <= col + 1'b1;
        else overflow <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr)
      for (int k = 0; k < DW; k++)
        mem[row[YW-1:0]][int'(col) * DW + k] <= s_data[DW-1-k];
    rd_pix <= mem[rd_row][rd_col];
  end

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  p_unsynced_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (!overflow && !frame_done));

  p_col_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col <= COL_END);

  p_anchor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rise && s_frm) |=> (row == '0 && col == '0 && synced));

  p_row_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (lp_rise && !s_frm && synced && row_ok) |=> (row == $past(row) + 1'b1 && col == '0));

  p_reset_r9: assert property (@(posedge clk)
    !rst_n |-> (!synced && !overflow && !frame_done));

endmodule

// File: tb/tb_lcd_frame_capture.sv
module tb_lcd_frame_capture;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4;
  localparam int COLS = 128;
  localparam int ROWS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [3:0] bus_data = '0;
  logic bus_sclk = 1'b0, bus_lp = 1'b0, bus_frm = 1'b0;
  logic [5:0] rd_row = '0;
  logic [6:0] rd_col = '0;
  logic rd_pix, frame_done, synced, overflow;

  int checks = 0, fails = 0, done_seen = 0, done_exp = 0;
  bit finished = 0, prev_done = 0;
  bit exp_pix [ROWS][COLS];

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_frame_capture dut (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit pat(input int sel, input int r, input int x);
    return bit'(((r * 7 + x * 3 + sel * 5) % (sel + 3)) == 0) ^ bit'(x == r + sel);
  endfunction

  // frame_done watch: counts pulses and checks single-cycle width (R8)
  always @(negedge clk) begin
    if (rst_n) begin
      if (frame_done) done_seen++;
      if (frame_done && prev_done) chk(0, "R8", "frame_done wider than one clock", 2, 1);
    end
    prev_done = frame_done;
  end

  task automatic step(input logic sc, input logic lp, input logic fr, input logic [3:0] d);
    bus_sclk = sc; bus_lp = lp; bus_frm = fr; bus_data = d;
    repeat (HOLD) @(negedge clk);
  endtask

  task automatic send_row(input int sel, input int r, input bit fr, input int nibs, input bit store);
    step(0, 1, fr, '0);
    step(0, 0, fr, '0);
    for (int c = 0; c < nibs; c++) begin
      logic [3:0] d;
      for (int k = 0; k < 4; k++) d[3-k] = pat(sel, r, (c * 4 + k) % COLS);
      step(1, 0, fr, d);
      step(0, 0, fr, d);
      if (store && c < COLS / 4)
        for (int k = 0; k < 4; k++) exp_pix[r][c * 4 + k] = d[3-k];
    end
    if (store && r == ROWS - 1 && nibs >= COLS / 4) done_exp++;
  endtask

  task automatic send_frame(input int sel);
    for (int r = 0; r < ROWS; r++) send_row(sel, r, r == 0, COLS / 4, 1);
    repeat (6) @(negedge clk);
  endtask

  task automatic check_row(input int r, input string req);
    int bad = 0, first = -1, act = 0, expv = 0;
    for (int x = 0; x < COLS; x++) begin
      rd_row = 6'(r); rd_col = 7'(x);
      @(negedge clk);
      if (rd_pix !== exp_pix[r][x]) begin
        if (first < 0) begin first = x; act = int'(rd_pix); expv = int'(exp_pix[r][x]); end
        bad++;
      end
    end
    chk(bad == 0, req, $sformatf("row %0d pixel %0d", r, first), act, expv);
  endtask

  task automatic check_all(input string req);
    for (int r = 0; r < ROWS; r++) check_row(r, req);
  endtask

  task automatic status(input string req, input bit s, input bit o);
    repeat (6) @(negedge clk);
    chk(synced == s, req, "synced", int'(synced), int'(s));
    chk(overflow == o, req, "overflow", int'(overflow), int'(o));
    chk(done_seen == done_exp, req, "frame_done count", done_seen, done_exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!synced && !overflow && !frame_done, "R9", "status in reset", int'({synced, overflow, frame_done}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    status("R9", 0, 0);

    // R5: rows before any frame start are discarded
    send_row(2, 0, 0, 32, 0);
    send_row(2, 1, 0, 32, 0);
    status("R5", 0, 0);

    // R1, R2, R8: first full frame
    send_frame(0);
    status("R8", 1, 0);
    check_row(0, "R2");
    check_all("R1");

    // R4 re-anchor mid-frame; R3 row advance
    send_row(1, 0, 1, 32, 1);
    send_row(1, 1, 0, 32, 1);
    send_row(1, 2, 0, 32, 1);
    send_row(2, 0, 1, 32, 1);
    repeat (6) @(negedge clk);
    check_row(0, "R4");
    check_row(1, "R3");
    check_row(2, "R3");
    check_row(3, "R3");
    status("R4", 1, 0);

    // R6: surplus transfer in row 5 of a new frame
    for (int r = 0; r < ROWS; r++) begin
      send_row(1, r, r == 0, r == 5 ? 33 : 32, 1);
      if (r == 5) status("R6", 1, 1);
    end
    repeat (6) @(negedge clk);
    status("R8", 1, 1);
    check_all("R6");

    // R7: a 65th row is ignored and flagged
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; repeat (2) @(negedge clk);
    send_frame(0);
    status("R7", 1, 0);
    send_row(2, 0, 0, 32, 0);
    status("R7", 1, 1);
    check_all("R7");

    // R5 again: after reset, stored frame survives unsynced traffic
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1; repeat (2) @(negedge clk);
    send_row(2, 0, 0, 32, 0);
    send_row(2, 1, 0, 32, 0);
    send_row(2, 63, 0, 32, 0);
    status("R5", 0, 0);
    check_row(0, "R5");
    check_row(1, "R5");
    check_row(63, "R5");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule